// File: doc/BRIEF.md
# I2C Slave Address Matcher (7-bit and 10-bit)

This block decides whether the local device is being addressed on an I2C bus. It has a byte stream from the receive shift register, with a strobe for each byte, and separate indications of a START or repeated START and of a STOP. It compares the header byte that follows each START against a stored slave address. The comparison rule depends on a mode input that selects 7-bit or 10-bit addressing. On a hit it raises an addressed-as-slave status, latches the direction bit and issues a one-clock match pulse, which the acknowledge logic uses on the ninth SCL clock.

In 10-bit mode the block compares only the first header byte. In that byte the trailing R/W bit counts as an address bit. When that byte matches as a write header, the block passes the next received byte to an external controller, which compares the low address bits itself. When that compare succeeds, the controller sets the stored address low bit through a set strobe. A later repeated-START read header, carrying a 1 in bit 0, then matches the stored byte. The controller clears the low bit again through a clear strobe.

The byte input uses a valid/ready handshake. The block accepts a byte in any cycle where both `rx_valid` and `rx_ready` are high. It never applies back-pressure, so `rx_ready` stays high. The producer may hold `rx_byte` only for the cycle it is accepted.

Top module: `i2c_addr_match`

## Requirements
- R1: `rx_ready` is 1 in every cycle from reset, and a byte is taken in each cycle where `rx_valid` is 1.
- R2: In 7-bit mode (`ten_bit_mode`=0), a header matches when bits 7..1 of the byte equal `addr_hi`. Byte bit 0 and the stored low bit take no part in the compare.
- R3: In 10-bit mode (`ten_bit_mode`=1), a header matches only when all eight bits equal {`addr_hi`, stored low bit}. The received bit 0 is compared like an address bit.
- R4: On a header match, `match_pulse` is high for exactly one clock, in the cycle after the byte is accepted. In that same cycle `addr_hit` reads 1 and `rx_dir` equals byte bit 0.
- R5: A header that does not match gives no pulse and clears `addr_hit` in the cycle after acceptance.
- R6: Only the first byte accepted after a `start_det` is treated as a header. Any other byte never produces `match_pulse`.
- R7: After a 10-bit header match with bit 0 = 0, the next accepted byte appears on `sec_byte`, with `sec_valid` high for one clock in the cycle after acceptance. After a 7-bit match, or a header with bit 0 = 1, `sec_valid` stays low.
- R8: The stored low bit is 0 after reset. `lsb_set` makes it 1 and `lsb_clr` makes it 0, and `lsb_clr` wins when both are high. Its value is observable through the R3 compare.
- R9: `stop_det` clears `addr_hit`, and no byte is compared until the next `start_det`. A `start_det` or `stop_det` takes precedence over a byte accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| addr_hi | input | 7 | Upper seven bits of the stored slave address |
| lsb_set | input | 1 | Strobe that sets the stored low bit |
| lsb_clr | input | 1 | Strobe that clears the stored low bit |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Byte accepted (always 1) |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| match_pulse | output | 1 | One-clock pulse on header match |
| addr_hit | output | 1 | Addressed-as-slave status |
| rx_dir | output | 1 | Latched R/W bit of the last matched header |
| sec_byte | output | 8 | Second 10-bit address byte for the external compare |
| sec_valid | output | 1 | One-clock strobe when `sec_byte` is updated |

## Verification
The 7-bit runs use headers that differ from the address only in bit 0, or only in the stored low bit. These tell whether either bit leaks into the compare. They are paired with a header that differs in bit 1, to confirm that a real mismatch clears the status. The 10-bit runs present the same upper bits with bit 0 both 0 and 1, before and after the low bit is set. This separates R/W-as-address behaviour from 7-bit behaviour and shows the effect of the set and clear strobes. Data bytes equal to the address are sent after a header and after a STOP, to show that only the byte following a START is compared. The repeated-START sequence checks that a read header opens no second-byte phase.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_SEC  = 2'd2,
    PH_DATA = 2'd3
  } am_phase_e;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int HI_W = 7
) (
  input  logic [HI_W:0]   cand,
  input  logic [HI_W-1:0] addr_hi,
  input  logic            low_bit,
  input  logic            wide_mode,
  output logic            hit
);
  logic upper_eq;
  logic full_eq;

  assign upper_eq = (cand[HI_W:1] == addr_hi);
  assign full_eq  = upper_eq && (cand[0] == low_bit);
  assign hit      = wide_mode ? full_eq : upper_eq;
endmodule

// File: rtl/i2c_am_lsb.sv
module i2c_am_lsb (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lsb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lsb_q <= 1'b0;
    else if (clr_i) lsb_q <= 1'b0;
    else if (set_i) lsb_q <= 1'b1;
  end

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !lsb_q);
  a_r8_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> lsb_q);
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
#(
  parameter int HI_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          take_i,
  input  logic [HI_W:0] byte_i,
  input  logic          hit_i,
  output logic          match_o,
  output logic          hit_flag_o,
  output logic          dir_o,
  output logic [HI_W:0] sec_o,
  output logic          sec_vld_o
);
  am_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      match_o    <= 1'b0;
      hit_flag_o <= 1'b0;
      dir_o      <= 1'b0;
      sec_o      <= '0;
      sec_vld_o  <= 1'b0;
    end else begin
      match_o   <= 1'b0;
      sec_vld_o <= 1'b0;
      if (stop_i) begin
        phase_q    <= PH_IDLE;
        hit_flag_o <= 1'b0;
      end else if (start_i) begin
        phase_q <= PH_HDR;
      end else if (take_i) begin
        unique case (phase_q)
          PH_HDR: begin
            if (hit_i) begin
              hit_flag_o <= 1'b1;
              dir_o      <= byte_i[0];
              match_o    <= 1'b1;
              phase_q    <= (wide_mode && !byte_i[0]) ? PH_SEC : PH_DATA;
            end else begin
              hit_flag_o <= 1'b0;
              phase_q    <= PH_DATA;
            end
          end
          PH_SEC: begin
            sec_o     <= byte_i;
            sec_vld_o <= 1'b1;
            phase_q   <= PH_DATA;
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);
  a_r4_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> hit_flag_o);
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!hit_flag_o && !match_o && !sec_vld_o));
  a_r7_sec_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sec_vld_o |-> hit_flag_o);
  a_r6_pulse_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(take_i));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int HI_W = 7,
  localparam int BYTE_W = HI_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_bit_mode,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              lsb_set,
  input  logic              lsb_clr,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              match_pulse,
  output logic              addr_hit,
  output logic              rx_dir,
  output logic [BYTE_W-1:0] sec_byte,
  output logic              sec_valid
);
  logic low_bit;
  logic cmp_hit;
  logic take;

  assign rx_ready = 1'b1;
  assign take     = rx_valid && rx_ready;

  i2c_am_lsb u_lsb (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (lsb_set),
    .clr_i (lsb_clr),
    .lsb_q (low_bit)
  );

  i2c_am_cmp #(.HI_W(HI_W)) u_cmp (
    .cand      (rx_byte),
    .addr_hi   (addr_hi),
    .low_bit   (low_bit),
    .wide_mode (ten_bit_mode),
    .hit       (cmp_hit)
  );

  i2c_am_seq #(.HI_W(HI_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_mode  (ten_bit_mode),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .take_i     (take),
    .byte_i     (rx_byte),
    .hit_i      (cmp_hit),
    .match_o    (match_pulse),
    .hit_flag_o (addr_hit),
    .dir_o      (rx_dir),
    .sec_o      (sec_byte),
    .sec_vld_o  (sec_valid)
  );

  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
  a_r7_sec_excl_match: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_valid && match_pulse));
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_bit_mode = 1'b0;
  logic [6:0] addr_hi = 7'h2A;
  logic       lsb_set = 1'b0, lsb_clr = 1'b0;
  logic       start_det = 1'b0, stop_det = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_byte = 8'h00;
  logic       match_pulse, addr_hit, rx_dir, sec_valid;
  logic [7:0] sec_byte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { bit is_sec; logic [7:0] val; string req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .ten_bit_mode(ten_bit_mode), .addr_hi(addr_hi),
    .lsb_set(lsb_set), .lsb_clr(lsb_clr), .start_det(start_det),
    .stop_det(stop_det), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .match_pulse(match_pulse), .addr_hit(addr_hit),
    .rx_dir(rx_dir), .sec_byte(sec_byte), .sec_valid(sec_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: every pulse must match the front of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (match_pulse || sec_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected pulse (match,sec)", {match_pulse, sec_valid}, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.is_sec) begin
            chk(sec_valid && !match_pulse, e.req, "sec_valid strobe", sec_valid, 1);
            chk(sec_byte == e.val, e.req, "sec_byte", sec_byte, e.val);
          end else begin
            chk(match_pulse && !sec_valid, e.req, "match_pulse", match_pulse, 1);
            chk(rx_dir == e.val[0], e.req, "rx_dir", rx_dir, e.val[0]);
            chk(addr_hit == 1'b1, e.req, "addr_hit with pulse", addr_hit, 1);
          end
        end
      end
    end
  end

  task automatic push(input bit is_sec, input logic [7:0] v, input string req);
    exp_t e;
    e.is_sec = is_sec; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    chk(sb.size() == 0, req, "scoreboard leftover", sb.size(), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(match_pulse == 0 && addr_hit == 0 && sec_valid == 0 && rx_dir == 0,
        "R9", "reset outputs", {match_pulse, addr_hit, sec_valid, rx_dir}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R1", "rx_ready", rx_ready, 1);

    // R2/R4: 7-bit read header
    do_start();
    push(1'b0, 8'h01, "R4"); send({7'h2A, 1'b1});
    chk(addr_hit == 1, "R4", "addr_hit after match", addr_hit, 1);
    // R6: data byte equal to header is not compared
    send({7'h2A, 1'b1});
    drain("R6");
    // R9: stop clears
    do_stop();
    chk(addr_hit == 0, "R9", "addr_hit after stop", addr_hit, 0);
    send({7'h2A, 1'b0});
    drain("R9");

    // R2: stored low bit ignored in 7-bit mode
    @(negedge clk); lsb_set = 1'b1; @(negedge clk); lsb_set = 1'b0;
    do_start();
    push(1'b0, 8'h00, "R2"); send({7'h2A, 1'b0});
    chk(rx_dir == 0, "R2", "rx_dir write", rx_dir, 0);
    send(8'h99);
    drain("R7");
    // R5: mismatch clears
    do_start();
    send({7'h2B, 1'b0});
    chk(addr_hit == 0, "R5", "addr_hit after mismatch", addr_hit, 1'b0);
    drain("R5");
    // R8: clear wins over set
    @(negedge clk); lsb_set = 1'b1; lsb_clr = 1'b1;
    @(negedge clk); lsb_set = 1'b0; lsb_clr = 1'b0;

    // R3/R7: 10-bit write header then second byte
    ten_bit_mode = 1'b1; addr_hi = 7'b1111011;
    do_start();
    push(1'b0, 8'h00, "R3"); push(1'b1, 8'h5C, "R7");
    send(8'hF6);
    send(8'h5C);
    send(8'hF6);
    drain("R7");
    // R3: R/W compared as address bit while low bit is 0 (also proves R8 clear-wins)
    do_start();
    send(8'hF7);
    chk(addr_hit == 0, "R8", "read header rejected with low bit 0", addr_hit, 0);
    drain("R3");
    // R8: confirm, repeated-start read header now matches, no second-byte phase
    @(negedge clk); lsb_set = 1'b1; @(negedge clk); lsb_set = 1'b0;
    do_start();
    push(1'b0, 8'h01, "R8"); send(8'hF7);
    send(8'h33);
    drain("R7");
    // R8: clear again, read header rejected
    @(negedge clk); lsb_clr = 1'b1; @(negedge clk); lsb_clr = 1'b0;
    do_start();
    send(8'hF7);
    chk(addr_hit == 0, "R8", "addr_hit after clear", addr_hit, 0);
    drain("R8");

    // R9: start in same cycle as byte -> byte ignored, next byte is header
    @(negedge clk); start_det = 1'b1; rx_valid = 1'b1; rx_byte = 8'hF6;
    @(negedge clk); start_det = 1'b0; rx_valid = 1'b0;
    drain("R9");
    push(1'b0, 8'h00, "R9"); send(8'hF6);
    drain("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule